// File: doc/BRIEF.md
# Configurable Logic and Arithmetic Function Unit

This block is a purely combinational function unit for a datapath. It takes two operand vectors and a carry-in. A 3-bit function code selects one of eight results. Seven codes pick a fixed bitwise function of the operands, and in that case each result bit depends only on the operand bits in the same position. The remaining code, 000, adds the two operands and the carry-in, and only that code can raise the carry output.

The operand width is a parameter with a default of 8. The unit holds no state, so a caller sees the result in the same cycle it drives the inputs. A surrounding pipeline can register the inputs, the outputs or both, as its timing needs.

Top module: `logic_arith_unit`

## Requirements
- R1: With funcSel = 3'b000 (funcSel[2] is the most significant code bit), {carryOut, result} equals opA + opB + carryIn, computed to WIDTH+1 bits.
- R2: For every funcSel value other than 3'b000, carryOut is 0.
- R3: funcSel = 3'b001 gives result = opA | opB.
- R4: funcSel = 3'b010 gives result = ~(opA & opB).
- R5: funcSel = 3'b011 gives result = opA ^ opB.
- R6: funcSel = 3'b100 gives result = ~(opA ^ opB).
- R7: funcSel = 3'b101 gives result = opA & opB.
- R8: funcSel = 3'b110 gives result = ~(opA | opB).
- R9: funcSel = 3'b111 gives result = all zeros for any operands and any carryIn.
- R10: For every code except 3'b000, carryIn has no effect on result or on carryOut.
- R11: With funcSel = 3'b000, opA and opB all ones and carryIn = 1, result is all ones and carryOut is 1. With carryIn = 0, result is all ones except bit 0, and carryOut is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| carryIn | input | 1 | Carry into the addition |
| funcSel | input | 3 | Function code; bit 2 is the most significant |
| result | output | WIDTH | Selected function result |
| carryOut | output | 1 | Carry out of the addition; 0 for all other codes |

## Verification
The bound checker compares every output against the code-specific relation whenever the inputs change. This covers the sum and carry of the add code, the six bitwise functions, the zero code, and the low carry output for all non-add codes. The checker looks at one input combination at a time, so it cannot show that carryIn is ignored outside add mode. The bench shows that property by applying the same operands with both carry values and comparing the two results. It also drives the all-ones carry corner directly, and it runs an exhaustive sweep at width 4 next to a random sweep at width 8.

// File: rtl/lau_pkg.sv
package lau_pkg;

  // Function code; bit 2 is the most significant bit of the code.
  typedef enum logic [2:0] {
    FN_ADD  = 3'b000,
    FN_OR   = 3'b001,
    FN_NAND = 3'b010,
    FN_XOR  = 3'b011,
    FN_XNOR = 3'b100,
    FN_AND  = 3'b101,
    FN_NOR  = 3'b110,
    FN_ZERO = 3'b111
  } funcCode_t;

  // Strobes from the decoder to the datapath.
  // truthTab[{a,b}] is the output bit for operand bits a and b.
  typedef struct packed {
    logic       addEn;
    logic [3:0] truthTab;
  } lauCtrl_t;

endpackage

// File: rtl/lau_control.sv
module lau_control
  import lau_pkg::*;
(
  input  logic [2:0] funcSel,
  output lauCtrl_t   ctrl
);

  funcCode_t code;
  assign code = funcCode_t'(funcSel);

  always_comb begin
    ctrl.addEn    = 1'b0;
    ctrl.truthTab = 4'b0000;
    unique case (code)
      FN_ADD:  ctrl.addEn    = 1'b1;
      FN_OR:   ctrl.truthTab = 4'b1110;
      FN_NAND: ctrl.truthTab = 4'b0111;
      FN_XOR:  ctrl.truthTab = 4'b0110;
      FN_XNOR: ctrl.truthTab = 4'b1001;
      FN_AND:  ctrl.truthTab = 4'b1000;
      FN_NOR:  ctrl.truthTab = 4'b0001;
      FN_ZERO: ctrl.truthTab = 4'b0000;
      default: ctrl.truthTab = 4'b0000;
    endcase
  end

endmodule

// File: rtl/lau_datapath.sv
module lau_datapath
  import lau_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  lauCtrl_t         ctrl,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  logic [WIDTH:0]   carryChain;
  logic [WIDTH-1:0] sumBits;
  logic [WIDTH-1:0] logicBits;

  assign carryChain[0] = carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    // Ripple-carry full adder cell.
    assign sumBits[i]      = opA[i] ^ opB[i] ^ carryChain[i];
    assign carryChain[i+1] = (opA[i] & opB[i]) | (carryChain[i] & (opA[i] ^ opB[i]));
    // Per-bit lookup of the selected two-input function.
    assign logicBits[i]    = ctrl.truthTab[{opA[i], opB[i]}];
  end

  assign result   = ctrl.addEn ? sumBits : logicBits;
  assign carryOut = ctrl.addEn & carryChain[WIDTH];

endmodule

// File: rtl/logic_arith_unit.sv
module logic_arith_unit
  import lau_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  logic [2:0]       funcSel,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  lauCtrl_t ctrlBus;

  lau_control uCtrl (
    .funcSel (funcSel),
    .ctrl    (ctrlBus)
  );

  lau_datapath #(.WIDTH(WIDTH)) uDp (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .ctrl     (ctrlBus),
    .result   (result),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/lau_checker.sv
module lau_checker #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             carryIn,
  input logic [2:0]       funcSel,
  input logic [WIDTH-1:0] result,
  input logic             carryOut
);

  logic [WIDTH:0] fullSum;
  assign fullSum = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};

  always_comb begin
    if (funcSel == 3'b000)
      assert_add_sum_R1: assert ({carryOut, result} == fullSum);
    if (funcSel != 3'b000)
      assert_carry_low_R2: assert (carryOut == 1'b0);
    if (funcSel == 3'b001)
      assert_or_R3: assert (result == (opA | opB));
    if (funcSel == 3'b010)
      assert_nand_R4: assert (result == ~(opA & opB));
    if (funcSel == 3'b011)
      assert_xor_R5: assert (result == (opA ^ opB));
    if (funcSel == 3'b100)
      assert_xnor_R6: assert (result == ~(opA ^ opB));
    if (funcSel == 3'b101)
      assert_and_R7: assert (result == (opA & opB));
    if (funcSel == 3'b110)
      assert_nor_R8: assert (result == ~(opA | opB));
    if (funcSel == 3'b111)
      assert_zero_R9: assert (result == '0);
  end

endmodule

bind logic_arith_unit lau_checker #(.WIDTH(WIDTH)) uChk (
  .opA      (opA),
  .opB      (opB),
  .carryIn  (carryIn),
  .funcSel  (funcSel),
  .result   (result),
  .carryOut (carryOut)
);

// File: tb/sim_logic_arith_unit.sv
module sim_logic_arith_unit;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int numChecks = 0;
  int numFails  = 0;
  bit done = 1'b0;

  // Width 8 instance
  logic [7:0] a8, b8, r8;
  logic       c8, co8;
  logic [2:0] s8;
  // Width 4 instance
  logic [3:0] a4, b4, r4;
  logic       c4, co4;
  logic [2:0] s4;

  logic_arith_unit #(.WIDTH(8)) u0 (
    .opA(a8), .opB(b8), .carryIn(c8), .funcSel(s8), .result(r8), .carryOut(co8)
  );
  logic_arith_unit #(.WIDTH(4)) u1 (
    .opA(a4), .opB(b4), .carryIn(c4), .funcSel(s4), .result(r4), .carryOut(co4)
  );

  // Reference model: returns {carry, result}, result masked to w bits.
  function automatic logic [8:0] refOut(logic [2:0] code, logic [7:0] a, logic [7:0] b,
                                        logic ci, int w);
    logic [7:0] m;
    logic [8:0] s;
    logic [7:0] r;
    m = 8'((9'd1 << w) - 9'd1);
    a = a & m;
    b = b & m;
    case (code)
      3'd0: begin
        s = {1'b0, a} + {1'b0, b} + {8'd0, ci};
        return {s[w], s[7:0] & m};
      end
      3'd1: r = a | b;
      3'd2: r = ~(a & b);
      3'd3: r = a ^ b;
      3'd4: r = ~(a ^ b);
      3'd5: r = a & b;
      3'd6: r = ~(a | b);
      default: r = 8'd0;
    endcase
    return {1'b0, r & m};
  endfunction

  function automatic string reqOf(logic [2:0] code);
    string names[8] = '{"R1", "R3", "R4", "R5", "R6", "R7", "R8", "R9"};
    return names[code];
  endfunction

  task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
    numChecks++;
    if (act !== exp) begin
      numFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive8(logic [2:0] s, logic [7:0] a, logic [7:0] b, logic c);
    @(negedge clk);
    s8 = s; a8 = a; b8 = b; c8 = c;
    @(posedge clk);
    #2;
  endtask

  task automatic drive4(logic [2:0] s, logic [3:0] a, logic [3:0] b, logic c);
    @(negedge clk);
    s4 = s; a4 = a; b4 = b; c4 = c;
    @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", numChecks, numFails);
    $finish;
  endtask

  initial begin
    s8 = 3'd0; a8 = '0; b8 = '0; c8 = 1'b0;
    s4 = 3'd0; a4 = '0; b4 = '0; c4 = 1'b0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #2;
    // Idle state: add of zeros
    check("R1 idle w8", {co8, r8}, 9'd0);
    check("R1 idle w4", {co4, 4'd0, r4}, 9'd0);

    // Exhaustive sweep at width 4
    for (int code = 0; code < 8; code++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int c = 0; c < 2; c++) begin
            drive4(3'(code), 4'(a), 4'(b), 1'(c));
            check({reqOf(3'(code)), " w4"}, {co4, 4'd0, r4},
                  refOut(3'(code), 8'(a), 8'(b), 1'(c), 4));
            if (code != 0)
              check("R2 w4", {8'd0, co4}, 9'd0);
          end

    // Random sweep at width 8
    for (int n = 0; n < 1500; n++) begin
      logic [2:0] code;
      logic [7:0] a, b;
      logic c;
      code = 3'($urandom_range(0, 7));
      a = 8'($urandom);
      b = 8'($urandom);
      c = 1'($urandom_range(0, 1));
      drive8(code, a, b, c);
      check({reqOf(code), " w8"}, {co8, r8}, refOut(code, a, b, c, 8));
      if (code != 3'd0)
        check("R2 w8", {8'd0, co8}, 9'd0);
    end

    // R10: carryIn has no effect outside add mode
    for (int code = 1; code < 8; code++)
      for (int n = 0; n < 20; n++) begin
        logic [7:0] a, b;
        logic [8:0] withZero;
        a = 8'($urandom);
        b = 8'($urandom);
        drive8(3'(code), a, b, 1'b0);
        withZero = {co8, r8};
        drive8(3'(code), a, b, 1'b1);
        check("R10 w8", {co8, r8}, withZero);
      end

    // R9: zero code with all-ones inputs
    drive8(3'b111, 8'hFF, 8'hFF, 1'b1);
    check("R9 all-ones w8", {co8, r8}, 9'd0);

    // R11: all-ones carry corner
    drive8(3'b000, 8'hFF, 8'hFF, 1'b1);
    check("R11 cin1 w8", {co8, r8}, {1'b1, 8'hFF});
    drive8(3'b000, 8'hFF, 8'hFF, 1'b0);
    check("R11 cin0 w8", {co8, r8}, {1'b1, 8'hFE});
    drive4(3'b000, 4'hF, 4'hF, 1'b1);
    check("R11 cin1 w4", {co4, 4'd0, r4}, {1'b1, 8'h0F});
    drive8(3'b000, 8'hFF, 8'h00, 1'b1);
    check("R1 wrap w8", {co8, r8}, {1'b1, 8'h00});

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      numChecks++;
      numFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

endmodule